// File: doc/BRIEF.md
# Control-Word Register-Bus Datapath

A datapath with seven general registers and an ALU. Each clock it takes one 14-bit control word. Two source multiplexers place either a register or the external input word on operand buses A and B. An operation field picks the ALU function. A destination field names the register, if any, that takes the ALU result at the end of the cycle. Because every clock can run one register-transfer step, a sequencer outside the block can run a program by issuing one word per cycle.

The ALU result is registered onto `data_out` together with a zero indication. Both are visible one clock after the control word is sampled, whether or not a register was written. The data width is a parameter with a default of 8 bits.

Top module: `regbus_datapath`

## Requirements
- R1: The control word splits into fields from the MSB down: bits 13:11 are the A source select, bits 10:8 are the B source select, bits 7:5 are the destination select and bits 4:0 are the operation code.
- R2: A source select of 1 to 7 puts register 1 to 7 on that bus. A source select of 0 puts `data_in` on that bus.
- R3: A destination select of 1 to 7 loads the ALU result into that register at the clock edge that samples the word. All other registers keep their values.
- R4: A destination select of 0 writes no register, and the result is still presented on `data_out`.
- R5: `data_out` shows the ALU result for the control word and `data_in` sampled at the previous rising edge.
- R6: The arithmetic operation codes are 00000 pass A, 00001 A+1, 00010 A+B, 00101 A−B and 00110 A−1. All of them wrap modulo 2^DATA_W, so an all-ones A incremented gives zero and a zero A decremented gives all ones.
- R7: The logic operation codes are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A.
- R8: Operation code 10000 shifts A right by one bit and code 11000 shifts A left by one bit. Both are logical shifts that shift in a zero.
- R9: Any operation code not listed in R6 to R8 gives a result of zero, and the destination select is still obeyed.
- R10: XOR with the same register selected on both buses gives zero, so the destination is cleared.
- R11: A synchronous active-high reset clears all registers and `data_out`, and sets `zero_out`.
- R12: `zero_out` is high exactly when `data_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 14 | Control word: A source, B source, destination, operation |
| data_in | input | DATA_W | External input word, selected by source code 0 |
| data_out | output | DATA_W | Registered ALU result |
| zero_out | output | 1 | Registered flag, high when the result is zero |

## Verification
The assertions assume that the control word and `data_in` are stable and known around each rising edge. They also assume that reset is held for at least one edge before the first word is applied. The bench meets both conditions by driving every input on the falling edge only, after a reset of several cycles. The random words can contain any operation code, including codes that are not defined. All three select fields therefore reach every value, and the register-file write checks fire on every destination.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int SEL_W = 3;
  localparam int OPR_W = 5;
  localparam int CW_W  = 3 * SEL_W + OPR_W;
  localparam int NREG  = (1 << SEL_W) - 1;

  typedef enum logic [OPR_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OPR_W-1:0] op;
  } ctl_word_t;
endpackage

// File: rtl/regbus_ctl_decode.sv
module regbus_ctl_decode
  import regbus_pkg::*;
(
  input  logic [CW_W-1:0]  word,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output logic [SEL_W-1:0] sel_d,
  output logic [OPR_W-1:0] op,
  output logic [NREG:1]    we
);
  ctl_word_t cw;
  assign cw    = ctl_word_t'(word);
  assign sel_a = cw.src_a;
  assign sel_b = cw.src_b;
  assign sel_d = cw.dst;
  assign op    = cw.op;

  for (genvar k = 1; k <= NREG; k++) begin : g_dec
    assign we[k] = (cw.dst == SEL_W'(k));
  end
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREG:1]          we,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NREG:1][DATA_W-1:0] regs
);
  logic [NREG:1][DATA_W-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else begin
      for (int k = 1; k <= NREG; k++) begin
        if (we[k]) regs_q[k] <= wdata;
      end
    end
  end

  assign regs = regs_q;

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst) $onehot0(we)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (we == '0) |=> $stable(regs_q)); // R4

  for (genvar k = 1; k <= NREG; k++) begin : g_chk
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst) we[k] |=> regs_q[k] == $past(wdata)); // R3
  end
endmodule

// File: rtl/regbus_srcmux.sv
module regbus_srcmux
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [SEL_W-1:0]          sel,
  input  logic [DATA_W-1:0]         ext,
  input  logic [NREG:1][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]         bus
);
  always_comb begin
    bus = ext;
    for (int k = 1; k <= NREG; k++) begin
      if (sel == SEL_W'(k)) bus = regs[k];
    end
  end
endmodule

// File: rtl/regbus_alu.sv
module regbus_alu
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OPR_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_PASS: y = a;
      OP_INC:  y = a + 1'b1;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DEC:  y = a - 1'b1;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHR:  y = a >> 1;
      OP_SHL:  y = a << 1;
      default: y = '0;
    endcase
  end

  always_comb begin
    if (op == OP_XOR && a == b) begin
      AST_XOR_SELF_CLEAR: assert (y == '0); // R10
    end
    if (op == OP_INC && a == '1) begin
      AST_INC_WRAP: assert (y == '0); // R6
    end
    if (op == OP_SHR) begin
      AST_SHR_ZERO_IN: assert (y[DATA_W-1] == 1'b0); // R8
    end
  end
endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [13:0]       ctl_word,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              zero_out
);
  logic [SEL_W-1:0]          sel_a, sel_b, sel_d;
  logic [OPR_W-1:0]          op;
  logic [NREG:1]             we;
  logic [NREG:1][DATA_W-1:0] regs;
  logic [DATA_W-1:0]         bus_a, bus_b, alu_y;
  logic [DATA_W-1:0]         out_q;
  logic                      zero_q;

  regbus_ctl_decode u_dec (
    .word(ctl_word), .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d), .op(op), .we(we)
  );

  regbus_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .we(we), .wdata(alu_y), .regs(regs)
  );

  regbus_srcmux #(.DATA_W(DATA_W)) u_mux_a (
    .sel(sel_a), .ext(data_in), .regs(regs), .bus(bus_a)
  );

  regbus_srcmux #(.DATA_W(DATA_W)) u_mux_b (
    .sel(sel_b), .ext(data_in), .regs(regs), .bus(bus_b)
  );

  regbus_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .a(bus_a), .b(bus_b), .y(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      out_q  <= alu_y;
      zero_q <= (alu_y == '0);
    end
  end

  assign data_out = out_q;
  assign zero_out = zero_q;

  AST_NO_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (sel_d == '0) |-> (we == '0)); // R4
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> data_out == $past(alu_y)); // R5
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst) zero_out == (data_out == '0)); // R12
endmodule

// File: tb/regbus_datapath_test.sv
`timescale 1ns/1ps
module regbus_datapath_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [13:0]  ctl_word = '0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] data_out;
  logic         zero_out;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] model [1:7];

  always #2 clk = ~clk;

  regbus_datapath #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .ctl_word(ctl_word), .data_in(data_in),
    .data_out(data_out), .zero_out(zero_out)
  );

  function automatic logic [W-1:0] alu_ref(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      5'b00000: return a;
      5'b00001: return W'(a + 1);
      5'b00010: return W'(a + b);
      5'b00101: return W'(a - b);
      5'b00110: return W'(a - 1);
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return {1'b0, a[W-1:1]};
      5'b11000: return {a[W-2:0], 1'b0};
      default:  return '0;
    endcase
  endfunction

  function automatic string op_tag(input logic [4:0] op);
    case (op)
      5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R2/R5/R6";
      5'b01000, 5'b01010, 5'b01100, 5'b01110: return "R2/R5/R7";
      5'b10000, 5'b11000: return "R2/R5/R8";
      default: return "R5/R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                      input logic [4:0] op, input logic [W-1:0] din, input string tag);
    logic [W-1:0] a, b, exp;
    a = (sa == 0) ? din : model[sa];
    b = (sb == 0) ? din : model[sb];
    exp = alu_ref(op, a, b);
    @(negedge clk);
    ctl_word = {sa, sb, sd, op};
    data_in  = din;
    @(posedge clk);
    #1;
    check(tag, data_out, exp);
    check("R12", W'(zero_out), W'(exp == '0));
    if (sd != 0) model[sd] = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 1; k <= 7; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 out", data_out, '0);
    check("R11 zero", W'(zero_out), W'(1));
    @(negedge clk);
    rst = 1'b0;
    // R11: every register reads back zero after reset
    for (int k = 1; k <= 7; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h5A, "R11 readback");
    // load registers from data_in
    for (int k = 1; k <= 7; k++) step(3'd0, 3'd0, 3'(k), 5'b00000, W'(8'h11 * k), "R2/R3 load");
    for (int k = 1; k <= 7; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, "R3 readback");
    // R1: field order, R1 <- R2 - R3
    step(3'd2, 3'd3, 3'd1, 5'b00101, 8'h00, "R1 sub");
    step(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, "R1 dest readback");
    // R4: no destination, registers untouched
    step(3'd4, 3'd5, 3'd0, 5'b00010, 8'h00, "R4 result shown");
    for (int k = 1; k <= 7; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, "R4 untouched");
    // R10: XOR same register clears destination
    step(3'd6, 3'd6, 3'd6, 5'b01100, 8'h00, "R10 xor self");
    step(3'd6, 3'd0, 3'd0, 5'b00000, 8'hFF, "R10 readback");
    // R6 wrap corners
    step(3'd0, 3'd0, 3'd7, 5'b00001, 8'hFF, "R6 inc wrap");
    step(3'd0, 3'd0, 3'd5, 5'b00110, 8'h00, "R6 dec wrap");
    step(3'd5, 3'd0, 3'd0, 5'b00000, 8'h00, "R6 dec readback");
    // R8 shifts with top/bottom bits set
    step(3'd0, 3'd0, 3'd0, 5'b10000, 8'h81, "R8 shr");
    step(3'd0, 3'd0, 3'd0, 5'b11000, 8'h81, "R8 shl");
    // R9: undefined code yields zero and still writes
    step(3'd0, 3'd0, 3'd3, 5'b00011, 8'hA5, "R9 undefined");
    step(3'd3, 3'd0, 3'd0, 5'b00000, 8'h77, "R9 dest cleared");
    // R7 with data_in on both buses
    step(3'd0, 3'd0, 3'd0, 5'b01110, 8'h3C, "R7 not");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [4:0] op;
      int pick;
      pick = int'($urandom_range(0, 12));
      case (pick)
        0: op = 5'b00000;  1: op = 5'b00001;  2: op = 5'b00010;
        3: op = 5'b00101;  4: op = 5'b00110;  5: op = 5'b01000;
        6: op = 5'b01010;  7: op = 5'b01100;  8: op = 5'b01110;
        9: op = 5'b10000;  10: op = 5'b11000;
        default: op = 5'($urandom);
      endcase
      step(3'($urandom), 3'($urandom), 3'($urandom), op, W'($urandom), op_tag(op));
    end
    for (int k = 1; k <= 7; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, "R3 final readback");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule